// File: doc/BRIEF.md
# Dual-Interrupt GPIO Bank with Wakeup

A bank of general-purpose pins behind a 32-bit memory-mapped register file. Software sets each pin's direction, drives an output latch and reads back a synchronised copy of the pin levels. Each pin configured as an input feeds four event detectors: low level, high level, rising edge and falling edge. Every detected event sets the pin's bit in two independent status registers. Each status register has its own enable mask and its own interrupt line, so two different consumers can service the same pins separately.

Status bits are cleared by writing ones to them. A level condition that still holds sets its bit again at once. The interrupt enables, the wakeup enables and the output latch also have set-only and clear-only alias offsets, so that one write can change a few bits without a read-modify-write. When the configuration allows it, an event on a wakeup-enabled pin raises a sticky wakeup request. A write to the configuration register with the soft-reset bit set returns the whole register file to its reset state. The two debounce registers are storage only.

Top module: `gpiob_bank`

## Requirements
- R1: After reset, the direction register (offset 0x34) reads all ones, so `pin_oe` is 0. The control register (0x30) reads 2. Offset 0x00 reads 0x18 and offset 0x14 reads 1. All other registers, both interrupts and `wake_req` are 0.
- R2: `pin_oe` is the inverse of the direction register (a 1 means input), and `pin_out` is the output latch (0x3C). A write to either takes effect on the pins from the clock edge that accepts it.
- R3: The aliases 0x64/0x60 (enable A), 0x74/0x70 (enable B), 0x84/0x80 (wakeup enable) and 0x94/0x90 (output latch) OR-in or clear the written one-bits of their target. Each alias reads back its target register.
- R4: When a rising-detect (0x48) or falling-detect (0x4C) bit is set on an input pin, a matching pin transition sets that bit in both status registers, 0x18 (A) and 0x28 (B). The bit becomes visible three clock edges after the pin changes.
- R5: While an input pin's level matches an enabled level detector (low 0x40, high 0x44), its status bit is set every cycle. A write-one-to-clear therefore leaves the bit set while the level holds.
- R6: Writing ones to a status register clears those bits when no event is present. The other status register is not changed.
- R7: A pin whose direction bit is 0 (output) sets no status bit, whatever its level or edges.
- R8: `irq_a` is 1 exactly when the AND of status A and enable A (0x1C) is non-zero, and `irq_b` follows status B and enable B (0x2C) in the same way. Both follow an enable write with no extra cycle.
- R9: An event sets `wake_req` only when configuration bit 2 is 1, configuration bits [4:3] are not 00, and the pin's bit in the wakeup-enable register (0x20) is 1. Once set, `wake_req` stays 1 until a reset.
- R10: Writing the configuration register (0x10) with bit 1 set resets every register of the bank and clears `wake_req`. The configuration register keeps only bits 0, 2, 3 and 4 of the written value, and the control register keeps 3 bits.
- R11: Writes to read-only offsets (0x00, 0x14, 0x38) and to unmapped offsets change nothing, and reads of unmapped offsets return 0. The debounce-time register (0x54) keeps 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_addr | input | ADDR_W | Byte offset for the read or the write |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| pin_in | input | NPINS | Raw pin levels |
| pin_out | output | NPINS | Output latch value |
| pin_oe | output | NPINS | Per-pin output drive enable |
| irq_a | output | 1 | Interrupt from status/enable set A |
| irq_b | output | 1 | Interrupt from status/enable set B |
| wake_req | output | 1 | Sticky wakeup request |

## Verification
A register write shows on `pin_oe`, `pin_out`, the interrupts and read data right after the edge that accepts it. A pin change passes two synchroniser flops and then the status flop, so its status bits, interrupts and wakeup appear after the third edge. Reads are combinational and show the state after the most recent edge. The bench drives inputs on the falling edge. It updates its own model at each rising edge and compares every output and the selected read value two time units later. This keeps each check in the exact cycle its result is due, and the directed sequences count those three edges out explicitly for the edge, level and wakeup cases.

// File: rtl/gpiob_pkg.sv
package gpiob_pkg;

   typedef logic [7:0] ofs_t;

   // byte offsets of the register file
   localparam ofs_t OFS_ID       = 8'h00;
   localparam ofs_t OFS_CFG      = 8'h10;
   localparam ofs_t OFS_DONE     = 8'h14;
   localparam ofs_t OFS_STA      = 8'h18;
   localparam ofs_t OFS_ENA      = 8'h1C;
   localparam ofs_t OFS_WEN      = 8'h20;
   localparam ofs_t OFS_STB      = 8'h28;
   localparam ofs_t OFS_ENB      = 8'h2C;
   localparam ofs_t OFS_CTRL     = 8'h30;
   localparam ofs_t OFS_DIR      = 8'h34;
   localparam ofs_t OFS_DIN      = 8'h38;
   localparam ofs_t OFS_DOUT     = 8'h3C;
   localparam ofs_t OFS_LLO      = 8'h40;
   localparam ofs_t OFS_LHI      = 8'h44;
   localparam ofs_t OFS_RISE     = 8'h48;
   localparam ofs_t OFS_FALL     = 8'h4C;
   localparam ofs_t OFS_DBEN     = 8'h50;
   localparam ofs_t OFS_DBT      = 8'h54;
   localparam ofs_t OFS_ENA_CLR  = 8'h60;
   localparam ofs_t OFS_ENA_SET  = 8'h64;
   localparam ofs_t OFS_ENB_CLR  = 8'h70;
   localparam ofs_t OFS_ENB_SET  = 8'h74;
   localparam ofs_t OFS_WEN_CLR  = 8'h80;
   localparam ofs_t OFS_WEN_SET  = 8'h84;
   localparam ofs_t OFS_DOUT_CLR = 8'h90;
   localparam ofs_t OFS_DOUT_SET = 8'h94;

   localparam logic [7:0] ID_VALUE   = 8'h18;
   localparam logic [4:0] CFG_KEEP   = 5'b11101;
   localparam int         CFG_SRST   = 1;
   localparam int         CFG_WAKEEN = 2;
   localparam int         CTRL_W     = 3;
   localparam logic [CTRL_W-1:0] CTRL_RST = 3'd2;

   // aliased registers: index, main / clear / set offsets
   localparam int NALIAS = 4;
   localparam int AL_ENA  = 0;
   localparam int AL_ENB  = 1;
   localparam int AL_WEN  = 2;
   localparam int AL_DOUT = 3;
   localparam ofs_t AL_LD  [NALIAS] = '{OFS_ENA,     OFS_ENB,     OFS_WEN,     OFS_DOUT};
   localparam ofs_t AL_CLR [NALIAS] = '{OFS_ENA_CLR, OFS_ENB_CLR, OFS_WEN_CLR, OFS_DOUT_CLR};
   localparam ofs_t AL_SET [NALIAS] = '{OFS_ENA_SET, OFS_ENB_SET, OFS_WEN_SET, OFS_DOUT_SET};

   // two status/enable/interrupt sets
   localparam int NIRQ = 2;
   localparam ofs_t ST_OFS [NIRQ] = '{OFS_STA, OFS_STB};

endpackage

// File: rtl/gpiob_sync.sv
module gpiob_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("gpiob_sync: STAGES must be at least 1");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= '0;
         end else begin
            if (s == 0) chain[s] <= d;
            else        chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpiob_detect.sv
module gpiob_detect #(
   parameter int NPINS = 32
) (
   input  logic [NPINS-1:0] cur,
   input  logic [NPINS-1:0] prev,
   input  logic [NPINS-1:0] is_in,
   input  logic [NPINS-1:0] det_lo,
   input  logic [NPINS-1:0] det_hi,
   input  logic [NPINS-1:0] det_rise,
   input  logic [NPINS-1:0] det_fall,
   output logic [NPINS-1:0] ev
);
   logic [NPINS-1:0] up, down, lvl;

   always_comb begin
      up   = cur & ~prev & det_rise;
      down = ~cur & prev & det_fall;
      lvl  = (cur & det_hi) | (~cur & det_lo);
      ev   = is_in & (up | down | lvl);
   end
endmodule

// File: rtl/gpiob_alias_reg.sv
module gpiob_alias_reg #(
   parameter int           W   = 32,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         ld,
   input  logic         set,
   input  logic         clr,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= RST;
      else if (flush) q <= RST;
      else if (ld)    q <= d;
      else if (set)   q <= q | d;
      else if (clr)   q <= q & ~d;
   end
endmodule

// File: rtl/gpiob_status.sv
module gpiob_status #(
   parameter int NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [NPINS-1:0] clr,
   input  logic [NPINS-1:0] ev,
   input  logic [NPINS-1:0] en,
   output logic [NPINS-1:0] stat,
   output logic             irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     stat <= '0;
      else if (flush) stat <= '0;
      else            stat <= (stat & ~clr) | ev;
   end

   assign irq = |(stat & en);
endmodule

// File: rtl/gpiob_bank.sv
module gpiob_bank
   import gpiob_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int DW          = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int DBT_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic              irq_a,
   output logic              irq_b,
   output logic              wake_req
);
   if (NPINS < 1 || NPINS > DW) begin : g_bad_npins
      $error("gpiob_bank: NPINS must be 1..DW");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("gpiob_bank: ADDR_W must be at least 8");
   end
   if (DBT_W < 1 || DBT_W > DW || DW < 8) begin : g_bad_dbt
      $error("gpiob_bank: DBT_W must be 1..DW and DW at least 8");
   end

   localparam logic [NPINS-1:0] ALL_IN = '1;

   function automatic logic hit(input logic wr, input logic [ADDR_W-1:0] a, input ofs_t o);
      return wr && (a == ADDR_W'(o));
   endfunction

   logic [NPINS-1:0] wpins;
   logic             soft_rst;
   logic [4:0]       cfg_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic [NPINS-1:0] dir_q, lo_q, hi_q, rise_q, fall_q, dben_q;
   logic [DBT_W-1:0] dbt_q;
   logic [NPINS-1:0] din, prev_q, ev;
   logic [NPINS-1:0] alias_q [NALIAS];
   logic [NPINS-1:0] stat [NIRQ];
   logic [NPINS-1:0] en   [NIRQ];
   logic [NIRQ-1:0]  irq;
   logic [NPINS-1:0] en_a, en_b, wen, out_q, stat_a, stat_b;
   logic             wake_hit, wake_q;

   assign wpins    = bus_wdata[NPINS-1:0];
   assign soft_rst = hit(bus_wr, bus_addr, OFS_CFG) && bus_wdata[CFG_SRST];

   // plain storage registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         ctrl_q <= CTRL_RST;
         dir_q  <= ALL_IN;
         lo_q   <= '0;
         hi_q   <= '0;
         rise_q <= '0;
         fall_q <= '0;
         dben_q <= '0;
         dbt_q  <= '0;
      end else if (soft_rst) begin
         cfg_q  <= bus_wdata[4:0] & CFG_KEEP;
         ctrl_q <= CTRL_RST;
         dir_q  <= ALL_IN;
         lo_q   <= '0;
         hi_q   <= '0;
         rise_q <= '0;
         fall_q <= '0;
         dben_q <= '0;
         dbt_q  <= '0;
      end else if (bus_wr) begin
         case (bus_addr)
            ADDR_W'(OFS_CFG):  cfg_q  <= bus_wdata[4:0] & CFG_KEEP;
            ADDR_W'(OFS_CTRL): ctrl_q <= bus_wdata[CTRL_W-1:0];
            ADDR_W'(OFS_DIR):  dir_q  <= wpins;
            ADDR_W'(OFS_LLO):  lo_q   <= wpins;
            ADDR_W'(OFS_LHI):  hi_q   <= wpins;
            ADDR_W'(OFS_RISE): rise_q <= wpins;
            ADDR_W'(OFS_FALL): fall_q <= wpins;
            ADDR_W'(OFS_DBEN): dben_q <= wpins;
            ADDR_W'(OFS_DBT):  dbt_q  <= bus_wdata[DBT_W-1:0];
            default: ;
         endcase
      end
   end

   // registers with set / clear aliases
   for (genvar k = 0; k < NALIAS; k++) begin : g_alias
      gpiob_alias_reg #(.W(NPINS), .RST('0)) i_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .flush (soft_rst),
         .ld    (hit(bus_wr, bus_addr, AL_LD[k])),
         .set   (hit(bus_wr, bus_addr, AL_SET[k])),
         .clr   (hit(bus_wr, bus_addr, AL_CLR[k])),
         .d     (wpins),
         .q     (alias_q[k])
      );
   end

   assign en_a  = alias_q[AL_ENA];
   assign en_b  = alias_q[AL_ENB];
   assign wen   = alias_q[AL_WEN];
   assign out_q = alias_q[AL_DOUT];

   // input path
   gpiob_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (din)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= din;
   end

   gpiob_detect #(.NPINS(NPINS)) i_detect (
      .cur      (din),
      .prev     (prev_q),
      .is_in    (dir_q),
      .det_lo   (lo_q),
      .det_hi   (hi_q),
      .det_rise (rise_q),
      .det_fall (fall_q),
      .ev       (ev)
   );

   // two parallel status / interrupt sets
   assign en[0] = en_a;
   assign en[1] = en_b;

   for (genvar n = 0; n < NIRQ; n++) begin : g_irq
      gpiob_status #(.NPINS(NPINS)) i_status (
         .clk   (clk),
         .rst_n (rst_n),
         .flush (soft_rst),
         .clr   (hit(bus_wr, bus_addr, ST_OFS[n]) ? wpins : '0),
         .ev    (ev),
         .en    (en[n]),
         .stat  (stat[n]),
         .irq   (irq[n])
      );
   end

   assign stat_a = stat[0];
   assign stat_b = stat[1];
   assign irq_a  = irq[0];
   assign irq_b  = irq[1];

   // sticky wakeup request
   assign wake_hit = (|(ev & wen)) && cfg_q[CFG_WAKEEN] && (|cfg_q[4:3]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        wake_q <= 1'b0;
      else if (soft_rst) wake_q <= 1'b0;
      else if (wake_hit) wake_q <= 1'b1;
   end

   assign wake_req = wake_q;
   assign pin_out  = out_q;
   assign pin_oe   = ~dir_q;

   // read mux
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFS_ID):   bus_rdata = DW'(ID_VALUE);
         ADDR_W'(OFS_CFG):  bus_rdata = DW'(cfg_q);
         ADDR_W'(OFS_DONE): bus_rdata = DW'(1);
         ADDR_W'(OFS_STA):  bus_rdata = DW'(stat_a);
         ADDR_W'(OFS_STB):  bus_rdata = DW'(stat_b);
         ADDR_W'(OFS_ENA), ADDR_W'(OFS_ENA_CLR), ADDR_W'(OFS_ENA_SET):
                            bus_rdata = DW'(en_a);
         ADDR_W'(OFS_ENB), ADDR_W'(OFS_ENB_CLR), ADDR_W'(OFS_ENB_SET):
                            bus_rdata = DW'(en_b);
         ADDR_W'(OFS_WEN), ADDR_W'(OFS_WEN_CLR), ADDR_W'(OFS_WEN_SET):
                            bus_rdata = DW'(wen);
         ADDR_W'(OFS_DOUT), ADDR_W'(OFS_DOUT_CLR), ADDR_W'(OFS_DOUT_SET):
                            bus_rdata = DW'(out_q);
         ADDR_W'(OFS_CTRL): bus_rdata = DW'(ctrl_q);
         ADDR_W'(OFS_DIR):  bus_rdata = DW'(dir_q);
         ADDR_W'(OFS_DIN):  bus_rdata = DW'(din);
         ADDR_W'(OFS_LLO):  bus_rdata = DW'(lo_q);
         ADDR_W'(OFS_LHI):  bus_rdata = DW'(hi_q);
         ADDR_W'(OFS_RISE): bus_rdata = DW'(rise_q);
         ADDR_W'(OFS_FALL): bus_rdata = DW'(fall_q);
         ADDR_W'(OFS_DBEN): bus_rdata = DW'(dben_q);
         ADDR_W'(OFS_DBT):  bus_rdata = DW'(dbt_q);
         default:           bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpiob_bank_chk.sv
module gpiob_bank_chk #(
   parameter int NPINS  = 32,
   parameter int DW     = 32,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DW-1:0]     bus_wdata,
   input logic [NPINS-1:0]  pin_oe,
   input logic              irq_a,
   input logic              wake_req,
   input logic [NPINS-1:0]  stat_a,
   input logic [NPINS-1:0]  stat_b,
   input logic [NPINS-1:0]  en_a,
   input logic [NPINS-1:0]  dir_q
);
   logic soft_wr, dir_wr;
   assign soft_wr = bus_wr && (bus_addr == ADDR_W'(8'h10)) && bus_wdata[1];
   assign dir_wr  = bus_wr && (bus_addr == ADDR_W'(8'h34));

   AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
      dir_wr |=> (pin_oe == ~$past(bus_wdata[NPINS-1:0]))); // R2

   AST_NEW_A_IN_B: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_a & ~$past(stat_a) & ~stat_b) == '0)); // R4

   AST_NO_OUTPUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_a & ~$past(stat_a) & ~$past(dir_q)) == '0)); // R7

   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_a |-> (en_a != '0)); // R8

   AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_req && !soft_wr) |=> wake_req); // R9

   AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      soft_wr |=> (!wake_req && stat_a == '0 && stat_b == '0)); // R10
endmodule

bind gpiob_bank gpiob_bank_chk #(.NPINS(NPINS), .DW(DW), .ADDR_W(ADDR_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .pin_oe    (pin_oe),
   .irq_a     (irq_a),
   .wake_req  (wake_req),
   .stat_a    (stat_a),
   .stat_b    (stat_b),
   .en_a      (en_a),
   .dir_q     (dir_q)
);

// File: tb/test_gpiob_bank.sv
module test_gpiob_bank;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out, pin_oe;
   logic        irq_a, irq_b, wake_req;

   int tests = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpiob_bank i_gpiob_bank (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq_a(irq_a), .irq_b(irq_b),
      .wake_req(wake_req)
   );

   // reference model state
   logic [4:0]  m_cfg;
   logic [2:0]  m_ctrl;
   logic [7:0]  m_dbt;
   logic [31:0] m_dir, m_out, m_lo, m_hi, m_rise, m_fall, m_dben;
   logic [31:0] m_ena, m_enb, m_wen, m_sa, m_sb, m_s1, m_s2, m_prev;
   logic        m_wake;
   logic [31:0] pins_now = '0;

   task automatic model_regs_reset();
      m_cfg = 0; m_ctrl = 3'd2; m_dbt = 0; m_dir = '1; m_out = 0;
      m_lo = 0; m_hi = 0; m_rise = 0; m_fall = 0; m_dben = 0;
      m_ena = 0; m_enb = 0; m_wen = 0; m_sa = 0; m_sb = 0; m_wake = 0;
   endtask

   function automatic logic [31:0] model_read(input logic [7:0] a);
      case (a)
         8'h00: return 32'h18;
         8'h10: return {27'd0, m_cfg};
         8'h14: return 32'd1;
         8'h18: return m_sa;
         8'h28: return m_sb;
         8'h1C, 8'h60, 8'h64: return m_ena;
         8'h2C, 8'h70, 8'h74: return m_enb;
         8'h20, 8'h80, 8'h84: return m_wen;
         8'h3C, 8'h90, 8'h94: return m_out;
         8'h30: return {29'd0, m_ctrl};
         8'h34: return m_dir;
         8'h38: return m_s2;
         8'h40: return m_lo;
         8'h44: return m_hi;
         8'h48: return m_rise;
         8'h4C: return m_fall;
         8'h50: return m_dben;
         8'h54: return {24'd0, m_dbt};
         default: return 32'd0;
      endcase
   endfunction

   task automatic model_step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                             input logic [31:0] pins);
      logic [31:0] ev, ca, cb;
      ev = m_dir & ((m_s2 & ~m_prev & m_rise) | (~m_s2 & m_prev & m_fall) |
                    (m_s2 & m_hi) | (~m_s2 & m_lo));
      ca = (wr && a == 8'h18) ? d : 32'd0;
      cb = (wr && a == 8'h28) ? d : 32'd0;
      if (wr && a == 8'h10 && d[1]) begin
         model_regs_reset();
         m_cfg = d[4:0] & 5'b11101;
      end else begin
         if ((|(ev & m_wen)) && m_cfg[2] && (|m_cfg[4:3])) m_wake = 1'b1;
         m_sa = (m_sa & ~ca) | ev;
         m_sb = (m_sb & ~cb) | ev;
         if (wr) begin
            case (a)
               8'h10: m_cfg = d[4:0] & 5'b11101;
               8'h1C: m_ena = d;
               8'h2C: m_enb = d;
               8'h20: m_wen = d;
               8'h3C: m_out = d;
               8'h30: m_ctrl = d[2:0];
               8'h34: m_dir = d;
               8'h40: m_lo = d;
               8'h44: m_hi = d;
               8'h48: m_rise = d;
               8'h4C: m_fall = d;
               8'h50: m_dben = d;
               8'h54: m_dbt = d[7:0];
               8'h60: m_ena = m_ena & ~d;
               8'h64: m_ena = m_ena | d;
               8'h70: m_enb = m_enb & ~d;
               8'h74: m_enb = m_enb | d;
               8'h80: m_wen = m_wen & ~d;
               8'h84: m_wen = m_wen | d;
               8'h90: m_out = m_out & ~d;
               8'h94: m_out = m_out | d;
               default: ;
            endcase
         end
      end
      m_prev = m_s2;
      m_s2 = m_s1;
      m_s1 = pins;
   endtask

   task automatic chk(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // one bus cycle; every output is compared with the model after the edge
   task automatic cyc(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      input string tag);
      @(negedge clk);
      bus_wr = wr; bus_addr = a; bus_wdata = d; pin_in = pins_now;
      @(posedge clk);
      model_step(wr, a, d, pins_now);
      #2;
      chk(tag, "pin_oe", pin_oe, ~m_dir);
      chk(tag, "pin_out", pin_out, m_out);
      chk(tag, "irq_a", {31'd0, irq_a}, {31'd0, |(m_sa & m_ena)});
      chk(tag, "irq_b", {31'd0, irq_b}, {31'd0, |(m_sb & m_enb)});
      chk(tag, "wake_req", {31'd0, wake_req}, {31'd0, m_wake});
      if (!wr) chk(tag, "rdata", bus_rdata, model_read(a));
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
      cyc(1'b1, a, d, tag);
   endtask

   // read with a literal expected value, independent of the model
   task automatic rd_exp(input logic [7:0] a, input logic [31:0] exp, input string tag);
      cyc(1'b0, a, 32'd0, tag);
      chk(tag, "literal", bus_rdata, exp);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [7:0] addrs [0:27];
      addrs = '{8'h00, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h28, 8'h2C, 8'h30, 8'h34,
                8'h38, 8'h3C, 8'h40, 8'h44, 8'h48, 8'h4C, 8'h50, 8'h54, 8'h60, 8'h64,
                8'h70, 8'h74, 8'h80, 8'h84, 8'h90, 8'h94, 8'h5C, 8'h04};
      void'($urandom(32'd20240611));
      model_regs_reset();
      m_s1 = 0; m_s2 = 0; m_prev = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_exp(8'h00, 32'h18, "R1");
      rd_exp(8'h14, 32'h1, "R1");
      rd_exp(8'h30, 32'h2, "R1");
      rd_exp(8'h34, 32'hFFFF_FFFF, "R1");
      chk("R1", "pin_oe reset", pin_oe, 32'h0);
      chk("R1", "wake reset", {31'd0, wake_req}, 32'h0);

      // R2 direction and output latch
      wr(8'h34, 32'hFFFF_0000, "R2");
      chk("R2", "pin_oe", pin_oe, 32'h0000_FFFF);
      wr(8'h94, 32'h0000_00F0, "R2");
      chk("R2", "pin_out", pin_out, 32'h0000_00F0);
      wr(8'h90, 32'h0000_0030, "R3");
      chk("R3", "pin_out clear alias", pin_out, 32'h0000_00C0);

      // R3 enable aliases
      wr(8'h64, 32'h3, "R3");
      wr(8'h60, 32'h1, "R3");
      rd_exp(8'h1C, 32'h2, "R3");
      rd_exp(8'h64, 32'h2, "R3");
      wr(8'h84, 32'h5, "R3");
      rd_exp(8'h80, 32'h5, "R3");

      // R4 rising edge on pin 8, three edges to status
      wr(8'h34, 32'hFFFF_FFFF, "R4");
      wr(8'h48, 32'h100, "R4");
      pins_now = 32'h100;
      rd_exp(8'h18, 32'h0, "R4");
      rd_exp(8'h18, 32'h0, "R4");
      rd_exp(8'h18, 32'h100, "R4");
      rd_exp(8'h28, 32'h100, "R4");

      // R8 interrupt follows enable at once
      chk("R8", "irq_a before enable", {31'd0, irq_a}, 32'h0);
      wr(8'h64, 32'h100, "R8");
      chk("R8", "irq_a", {31'd0, irq_a}, 32'h1);
      chk("R8", "irq_b", {31'd0, irq_b}, 32'h0);

      // R6 clear on one set only
      wr(8'h18, 32'h100, "R6");
      chk("R6", "irq_a after clear", {31'd0, irq_a}, 32'h0);
      rd_exp(8'h18, 32'h0, "R6");
      rd_exp(8'h28, 32'h100, "R6");

      // R5 level high on pin 9 survives clear while held
      wr(8'h44, 32'h200, "R5");
      pins_now = 32'h300;
      repeat (3) cyc(1'b0, 8'h38, 0, "R5");
      rd_exp(8'h18, 32'h200, "R5");
      wr(8'h18, 32'h200, "R5");
      rd_exp(8'h18, 32'h200, "R5");
      pins_now = 32'h100;
      repeat (3) cyc(1'b0, 8'h38, 0, "R5");
      wr(8'h18, 32'h200, "R6");
      rd_exp(8'h18, 32'h0, "R6");

      // R7 output pin 10 sets nothing
      wr(8'h34, 32'hFFFF_FBFF, "R7");
      wr(8'h48, 32'h400, "R7");
      wr(8'h44, 32'h400, "R7");
      pins_now = 32'h500;
      repeat (4) cyc(1'b0, 8'h28, 0, "R7");
      chk("R7", "status b bit 10", bus_rdata & 32'h400, 32'h0);

      // R9 wakeup gating and stickiness on pin 11
      wr(8'h44, 32'h0, "R9");
      wr(8'h84, 32'h800, "R9");
      wr(8'h48, 32'h800, "R9");
      wr(8'h10, 32'h04, "R9");
      pins_now = 32'h900;
      repeat (4) cyc(1'b0, 8'h10, 0, "R9");
      chk("R9", "wake with idle 00", {31'd0, wake_req}, 32'h0);
      wr(8'h10, 32'h0C, "R9");
      pins_now = 32'h100;
      repeat (3) cyc(1'b0, 8'h10, 0, "R9");
      pins_now = 32'h900;
      repeat (3) cyc(1'b0, 8'h10, 0, "R9");
      chk("R9", "wake set", {31'd0, wake_req}, 32'h1);
      pins_now = 32'h100;
      repeat (4) cyc(1'b0, 8'h10, 0, "R9");
      chk("R9", "wake sticky", {31'd0, wake_req}, 32'h1);

      // R10 soft reset and field widths
      wr(8'h10, 32'h1F, "R10");
      chk("R10", "wake cleared", {31'd0, wake_req}, 32'h0);
      rd_exp(8'h10, 32'h1D, "R10");
      rd_exp(8'h34, 32'hFFFF_FFFF, "R10");
      rd_exp(8'h84, 32'h0, "R10");
      wr(8'h30, 32'hFF, "R10");
      rd_exp(8'h30, 32'h7, "R10");

      // R11 read-only and unmapped offsets
      wr(8'h00, 32'hDEAD_BEEF, "R11");
      wr(8'h38, 32'hFFFF_FFFF, "R11");
      wr(8'h5C, 32'hFFFF_FFFF, "R11");
      rd_exp(8'h00, 32'h18, "R11");
      rd_exp(8'h5C, 32'h0, "R11");
      rd_exp(8'h38, 32'h100, "R11");
      wr(8'h54, 32'h1FF, "R11");
      rd_exp(8'h54, 32'hFF, "R11");

      // constrained random traffic checked against the model
      for (int i = 0; i < 4000; i++) begin
         logic [7:0]  a;
         logic [31:0] d;
         a = addrs[$urandom % 28];
         d = $urandom;
         if (a == 8'h10 && ($urandom % 16) != 0) d[1] = 1'b0;
         if (($urandom % 4) == 0) pins_now = pins_now ^ (32'h1 << ($urandom % 32));
         if (($urandom % 32) == 0) pins_now = $urandom;
         cyc(($urandom % 3) == 0, a, d, "R4 R5 R8 random");
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule